// File: doc/BRIEF.md
# Password-Protected Watchdog Timer

This block is a watchdog timer on a single-cycle register bus. Software starts, stops and refreshes the timer through a control word. The control word only takes effect when two writes arrive back to back: the first carries an arming key and the second carries a commit key. The timer is a 16-bit down-counter. A prescaler with four ratios paces the counter. The block raises a pre-warning level when the count falls into a programmable last fraction of the full range. It pulses a reset request when the count runs out.

A sticky cause flag records that an expiry happened. Only the power-on reset clears this flag. The system reset input, which the reset request normally drives, clears the rest of the state. Software can therefore see after a reboot that the watchdog caused it. A refresh uses the same two-write sequence, with bit 31 set and a new reload value. A read at offset 0x8 returns the running flag and the live count.

Top module: `pwd_wdog`

## Requirements
- R1: After power-on reset, reads at offsets 0x0 and 0x8 return 0, and `prewarn_o`, `rst_req_o` and `cause_o` are low.
- R2: A control write (offset 0x0) is applied only when it carries 0xDC in bits 23:16 and the previous bus write was to offset 0x0 with 0xBE in bits 23:16. The arming write itself changes no field.
- R3: A write with any other key byte, a commit-key write that does not immediately follow an arming write, and any write to an offset other than 0x0 all leave every control field and the counter unchanged. Each of them also disarms the sequence.
- R4: A read at offset 0x0 returns {running, reserved bits 30:28, warn select 27:26, prescale select 25:24, 8'h00, reload 15:0}. A read at offset 0x8 returns {running at bit 31, zeros, count at bits 15:0}. Any other offset reads 0.
- R5: An applied write with bit 31 = 1 starts the timer, or refreshes it if it is already running. It loads the count from bits 15:0 and restarts the prescaler. An applied write with bit 31 = 0 stops the timer, and the count holds.
- R6: Prescale select values 0, 1, 2 and 3 divide the clock by 1, 64, 4096 and 262144. The count drops by one per prescaler tick. With divide-by-1 the first decrement lands one clock after the load.
- R7: Warn select values 0, 1, 2 and 3 set the threshold to 0x7FFF, 0x3FFF, 0x1FFF and 0x0FFF. `prewarn_o` is high whenever the timer runs with a count at or below the threshold, and it updates on the same edge as the count. Once set, it stays high until the next applied write, which recomputes it.
- R8: A tick at a count of 1 or 0 sets the count to 0 and stops the timer. `rst_req_o` is then high for exactly one clock.
- R9: `cause_o` rises one clock after `rst_req_o` and stays high until `por_n` is asserted. A low `sys_rst_n` clears the control fields, the counter, the pre-warning and the unlock state, but not `cause_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears everything |
| sys_rst_n | input | 1 | Synchronous system reset, active low; keeps the cause flag |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| prewarn_o | output | 1 | Pre-warning level |
| rst_req_o | output | 1 | One-cycle reset request on expiry |
| cause_o | output | 1 | Sticky watchdog-caused-reset flag |

## Verification
On every cycle the assertions check the following: the reset request is a single-cycle pulse that leaves the counter stopped at zero; the cause flag follows the request and never drops; the pre-warning is high at or below the threshold; the control fields change only on a commit; and the count moves by at most one step between commits. Only the bench scenarios can show that the key sequence is decoded correctly, including disarming by a stray write and by a wrong key. The same holds for the exact tick spacing of each prescale ratio, the cycle on which the expiry lands, the refresh clearing the pre-warning, and the cause flag surviving a system reset.

// File: rtl/pwd_wdog_pkg.sv
package pwd_wdog_pkg;

    localparam int DATA_W     = 32;
    localparam int CNT_W      = 16;
    localparam int KEY_LSB    = 16;
    localparam int KEY_W      = 8;
    localparam int RUN_BIT    = 31;
    localparam int RSVD_LSB   = 28;
    localparam int WARN_LSB   = 26;
    localparam int PRE_LSB    = 24;
    localparam logic [KEY_W-1:0] KEY_ARM    = 8'hBE;
    localparam logic [KEY_W-1:0] KEY_COMMIT = 8'hDC;

    typedef struct packed {
        logic [2:0]       rsvd;
        logic [1:0]       warn_sel;
        logic [1:0]       pre_sel;
        logic [CNT_W-1:0] reload;
    } ctrl_t;

    // Threshold is the full range shifted right by (select + 1).
    function automatic logic [CNT_W-1:0] warn_limit(input logic [1:0] sel);
        return {CNT_W{1'b1}} >> ({1'b0, sel} + 3'd1);
    endfunction

endpackage

// File: rtl/pwd_wdog_unlock.sv
module pwd_wdog_unlock
    import pwd_wdog_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             sys_rst_n,
    input  logic             ctrl_wr,
    input  logic             other_wr,
    input  logic [KEY_W-1:0] key,
    output logic             commit
);

    typedef struct packed {
        logic armed;
    } unl_t;

    unl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!sys_rst_n) begin
            st_d.armed = 1'b0;
        end else if (ctrl_wr) begin
            // Every control write re-evaluates the arm state.
            st_d.armed = (key == KEY_ARM);
        end else if (other_wr) begin
            st_d.armed = 1'b0;
        end
    end

    assign commit = sys_rst_n && ctrl_wr && st_q.armed && (key == KEY_COMMIT);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pwd_wdog_prescale.sv
module pwd_wdog_prescale #(
    parameter  int STEP = 6,
    localparam int PW   = 3 * STEP
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       sys_rst_n,
    input  logic       run,
    input  logic       clear,
    input  logic [1:0] sel,
    output logic       tick
);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_t;

    pre_t st_d, st_q;
    logic [PW-1:0] lims [4];
    logic [PW-1:0] lim;

    for (genvar g = 0; g < 4; g++) begin : g_lim
        assign lims[g] = PW'((64'd1 << (g * STEP)) - 64'd1);
    end

    assign lim  = lims[sel];
    assign tick = run && (st_q.cnt == lim);

    always_comb begin
        st_d = st_q;
        if (!sys_rst_n || clear || !run || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pwd_wdog_count.sv
module pwd_wdog_count
    import pwd_wdog_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             sys_rst_n,
    input  logic             load,
    input  logic             load_run,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] thr,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic             warn,
    output logic             expire
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             warn;
        logic             expire;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.expire = 1'b0;
        if (!sys_rst_n) begin
            st_d = '0;
        end else if (load) begin
            st_d.run  = load_run;
            if (load_run) st_d.cnt = load_val;
            st_d.warn = st_d.run && (st_d.cnt <= thr);
        end else if (tick) begin
            if (st_q.cnt <= CNT_W'(1)) begin
                st_d.cnt    = '0;
                st_d.run    = 1'b0;
                st_d.expire = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
            st_d.warn = st_q.warn | (st_d.run && (st_d.cnt <= thr));
        end
    end

    assign cnt    = st_q.cnt;
    assign run    = st_q.run;
    assign warn   = st_q.warn;
    assign expire = st_q.expire;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pwd_wdog.sv
module pwd_wdog
    import pwd_wdog_pkg::*;
#(
    parameter int              ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h0,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'h8,
    parameter int              DIV_STEP = 6
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              prewarn_o,
    output logic              rst_req_o,
    output logic              cause_o
);

    typedef struct packed {
        ctrl_t ctrl;
        logic  cause;
    } top_t;

    top_t st_d, st_q;

    logic             ctrl_wr, other_wr, commit_w, tick_w, run_w;
    logic [CNT_W-1:0] cnt_w, thr_w;
    ctrl_t            ctrl_w;

    assign ctrl_wr  = bus_we && (bus_addr == CTRL_OFS);
    assign other_wr = bus_we && (bus_addr != CTRL_OFS);

    pwd_wdog_unlock u_unlock (
        .clk      (clk),
        .por_n    (por_n),
        .sys_rst_n(sys_rst_n),
        .ctrl_wr  (ctrl_wr),
        .other_wr (other_wr),
        .key      (bus_wdata[KEY_LSB +: KEY_W]),
        .commit   (commit_w)
    );

    always_comb begin
        st_d = st_q;
        if (!sys_rst_n) begin
            st_d.ctrl = '0;
        end else if (commit_w) begin
            st_d.ctrl.rsvd     = bus_wdata[RSVD_LSB +: 3];
            st_d.ctrl.warn_sel = bus_wdata[WARN_LSB +: 2];
            st_d.ctrl.pre_sel  = bus_wdata[PRE_LSB +: 2];
            st_d.ctrl.reload   = bus_wdata[CNT_W-1:0];
        end
        st_d.cause = st_q.cause | rst_req_o;
    end

    assign thr_w = warn_limit(st_d.ctrl.warn_sel);

    pwd_wdog_prescale #(.STEP(DIV_STEP)) u_pre (
        .clk      (clk),
        .por_n    (por_n),
        .sys_rst_n(sys_rst_n),
        .run      (run_w),
        .clear    (commit_w),
        .sel      (st_q.ctrl.pre_sel),
        .tick     (tick_w)
    );

    pwd_wdog_count u_cnt (
        .clk      (clk),
        .por_n    (por_n),
        .sys_rst_n(sys_rst_n),
        .load     (commit_w),
        .load_run (bus_wdata[RUN_BIT]),
        .load_val (bus_wdata[CNT_W-1:0]),
        .thr      (thr_w),
        .tick     (tick_w),
        .cnt      (cnt_w),
        .run      (run_w),
        .warn     (prewarn_o),
        .expire   (rst_req_o)
    );

    assign ctrl_w  = st_q.ctrl;
    assign cause_o = st_q.cause;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_OFS) begin
            bus_rdata = {run_w, ctrl_w.rsvd, ctrl_w.warn_sel, ctrl_w.pre_sel, 8'h00, 16'(ctrl_w.reload)};
        end else if (bus_addr == STAT_OFS) begin
            bus_rdata = {run_w, 15'h0000, 16'(cnt_w)};
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pwd_wdog_chk.sv
module pwd_wdog_chk
    import pwd_wdog_pkg::*;
(
    input logic             clk,
    input logic             por_n,
    input logic             sys_rst_n,
    input logic             commit,
    input logic             run,
    input logic [CNT_W-1:0] cnt,
    input logic             warn,
    input logic             rst_req,
    input logic             cause,
    input ctrl_t            ctrl
);

    // R8
    rstreq_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |=> !rst_req);

    // R8
    rstreq_stopped_chk: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |-> (!run && cnt == '0));

    // R9
    cause_follow_chk: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |=> cause);

    // R9
    cause_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        cause |=> cause);

    // R7
    warn_level_chk: assert property (@(posedge clk) disable iff (!por_n)
        (run && cnt <= warn_limit(ctrl.warn_sel)) |-> warn);

    // R3
    ctrl_guard_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        !commit |=> $stable(ctrl));

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (run && !commit) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1 || cnt == '0));

endmodule

bind pwd_wdog pwd_wdog_chk u_chk (
    .clk      (clk),
    .por_n    (por_n),
    .sys_rst_n(sys_rst_n),
    .commit   (commit_w),
    .run      (run_w),
    .cnt      (cnt_w),
    .warn     (prewarn_o),
    .rst_req  (rst_req_o),
    .cause    (cause_o),
    .ctrl     (ctrl_w)
);

// File: tb/pwd_wdog_test.sv
module pwd_wdog_test;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        prewarn_o, rst_req_o, cause_o;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pwd_wdog uut (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .prewarn_o(prewarn_o),
        .rst_req_o(rst_req_o), .cause_o(cause_o)
    );

    // {addr, wdata, exp_run, exp_warn, exp_cnt}; prescale 3 keeps the count still.
    localparam logic [53:0] VEC [14] = '{
        {4'h0, 32'h03BE0000, 1'b0, 1'b0, 16'h0000},
        {4'h0, 32'h8FDC1234, 1'b1, 1'b0, 16'h1234},
        {4'h0, 32'h8FDC0500, 1'b1, 1'b0, 16'h1234},
        {4'h0, 32'h00BE0000, 1'b1, 1'b0, 16'h1234},
        {4'h8, 32'h8FDC0777, 1'b1, 1'b0, 16'h1234},
        {4'h0, 32'h8FDC0700, 1'b1, 1'b0, 16'h1234},
        {4'h0, 32'h00BE0000, 1'b1, 1'b0, 16'h1234},
        {4'h0, 32'h8FDC0ABC, 1'b1, 1'b1, 16'h0ABC},
        {4'h0, 32'h00BF0000, 1'b1, 1'b1, 16'h0ABC},
        {4'h0, 32'h8FDC2000, 1'b1, 1'b1, 16'h0ABC},
        {4'h0, 32'h00BE0000, 1'b1, 1'b1, 16'h0ABC},
        {4'h0, 32'h8FDC2000, 1'b1, 1'b0, 16'h2000},
        {4'h0, 32'h00BE0000, 1'b1, 1'b0, 16'h2000},
        {4'h0, 32'h0FDC2000, 1'b0, 1'b0, 16'h2000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one write, return at the negedge after the capturing edge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic summary;
        $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        #800000;
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(4'h0, r); chk("R1 ctrl read", r, 32'h0);
        rd(4'h8, r); chk("R1 status read", r, 32'h0);
        chk("R1 outputs", {29'h0, prewarn_o, rst_req_o, cause_o}, 32'h0);
        @(negedge clk); por_n = 1'b1;
        @(negedge clk);

        // R2 R3 R5 R7 vector walk
        for (int i = 0; i < 14; i++) begin
            wr(VEC[i][53:50], VEC[i][49:18]);
            rd(4'h8, r);
            chk($sformatf("R2/R3 row %0d count", i), {16'h0, r[15:0]}, {16'h0, VEC[i][15:0]});
            chk($sformatf("R5 row %0d run", i), {31'h0, r[31]}, {31'h0, VEC[i][17]});
            chk($sformatf("R7 row %0d warn", i), {31'h0, prewarn_o}, {31'h0, VEC[i][16]});
        end
        // R4 readback of stopped control word, key field reads zero
        rd(4'h0, r); chk("R4 ctrl readback", r, 32'h0F002000);
        rd(4'h4, r); chk("R4 unmapped read", r, 32'h0);

        // R7 refresh clears warning (divide-by-1, threshold 0x0FFF)
        wr(4'h0, 32'h00BE0000);
        wr(4'h0, 32'h8CDC1000);
        rd(4'h8, r); chk("R5 load 0x1000", r, 32'h80001000);
        chk("R7 above threshold", {31'h0, prewarn_o}, 32'h0);
        cyc(1);
        rd(4'h8, r); chk("R6 first decrement", r, 32'h80000FFF);
        chk("R7 at threshold", {31'h0, prewarn_o}, 32'h1);
        wr(4'h0, 32'h00BE0000);
        wr(4'h0, 32'h8CDC1000);
        rd(4'h8, r); chk("R5 refresh reload", r, 32'h80001000);
        chk("R7 refresh clears", {31'h0, prewarn_o}, 32'h0);

        // R8 expiry from 5, divide-by-1, warn select 0
        wr(4'h0, 32'h00BE0000);
        wr(4'h0, 32'h80DC0005);
        rd(4'h8, r); chk("R5 load 5", r, 32'h80000005);
        chk("R7 low count warns", {31'h0, prewarn_o}, 32'h1);
        for (int k = 1; k <= 5; k++) begin
            cyc(1);
            rd(4'h8, r);
            chk($sformatf("R6 count step %0d", k), {16'h0, r[15:0]}, 32'(5 - k));
            chk($sformatf("R8 request step %0d", k), {31'h0, rst_req_o}, {31'h0, k == 5});
        end
        chk("R8 stopped", {31'h0, r[31]}, 32'h0);
        cyc(1);
        chk("R8 single pulse", {31'h0, rst_req_o}, 32'h0);
        chk("R9 cause set", {31'h0, cause_o}, 32'h1);

        // R6 divide-by-64
        wr(4'h0, 32'h00BE0000);
        wr(4'h0, 32'h8DDC0003);
        rd(4'h0, r); chk("R4 running ctrl", r, 32'h8D000003);
        cyc(63);
        rd(4'h8, r); chk("R6 div64 before tick", r, 32'h80000003);
        cyc(1);
        rd(4'h8, r); chk("R6 div64 after tick", r, 32'h80000002);

        // R9 system reset keeps cause
        sys_rst_n = 1'b0;
        cyc(1);
        sys_rst_n = 1'b1;
        rd(4'h8, r); chk("R9 sys reset status", r, 32'h0);
        rd(4'h0, r); chk("R9 sys reset ctrl", r, 32'h0);
        chk("R9 cause survives", {31'h0, cause_o}, 32'h1);
        por_n = 1'b0;
        #1;
        chk("R9 por clears cause", {31'h0, cause_o}, 32'h0);
        @(negedge clk); por_n = 1'b1;

        done = 1'b1;
        summary();
        $finish;
    end

endmodule